// File: doc/BRIEF.md
# Split-Immediate Floating-Point Constant Loader

This unit executes two 32-bit instructions that assemble a floating-point constant in a 32-entry, 64-bit floating-point register file from 16-bit immediates. The upper-half form takes its immediate as the top 16 bits of a single-precision pattern, zeroes the bottom 16 bits, widens the pattern to double precision and writes it to the target register. The lower-half form reads the target register, narrows it to single precision, replaces the bottom 16 bits with its immediate, widens the result again and writes it back. Issuing an upper-half load and then a lower-half insert places any 32-bit single-precision constant in a register as a double.

The 16-bit immediate is split across three non-adjacent fields of the instruction word. The unit gathers the immediate, decodes the two opcode fields and drives the register file's read address combinationally. It returns the write one cycle after the valid strobe. When a lower-half insert targets the register written in the previous cycle, the unit forwards its own pending result in place of the stale read data.

Top module: `fp_imm_load_unit`

## Requirements
- R1: Field layout (bit 31 is the first instruction bit): primary opcode is `instr[31:26]` and must equal 22; target register is `instr[25:21]`; the immediate is `{instr[15:6], instr[20:16], instr[0]}`, so `instr[0]` is immediate bit 0 and `instr[15]` is immediate bit 15; extended opcode is `instr[5:1]`.
- R2: Extended opcode 5'b00011 (upper-half load) writes the double-precision widening of `{imm, 16'h0000}`. For example, 0x4000 gives 0x4000000000000000, 0x4048 gives 0x4009000000000000 and 0x3E80 gives 0x3FD0000000000000.
- R3: The sign of the result is immediate bit 15. Upper-half load of 0xC048 gives 0xC009000000000000.
- R4: Extended opcode 5'b01011 (lower-half insert) narrows the target register to single precision, replaces bits 15:0 with the immediate and writes the widened result. Upper 0x3F80 followed by insert 0x4000 gives 0x3FF0080000000000.
- R5: Each valid legal instruction produces exactly one write (`wr_en` high for one cycle) in the cycle after the strobe, to the target register and in issue order. Without the strobe nothing is written.
- R6: A primary opcode other than 22 raises `illegal` for one cycle, one cycle after the strobe, and writes nothing.
- R7: An extended opcode other than the two defined values raises `illegal` and writes nothing.
- R8: A lower-half insert issued in the cycle directly after a write to the same register uses that write's value. Upper 0x4049 then insert 0x0FD0 back to back gives 0x400921FA00000000, and with 0xC049 it gives 0xC00921FA00000000. An insert to a different register uses the read port.
- R9: A single-precision zero widens to a signed double zero. Upper 0x8000 gives 0x8000000000000000.
- R10: An all-ones single exponent maps to an all-ones double exponent with the fraction shifted left by 29. Upper 0x7F80 gives 0x7FF0000000000000 and upper 0x7FC0 gives 0x7FF8000000000000.
- R11: Denormal single-precision values are normalized when widened, and narrowing turns them back into denormals. Upper 0x0040 gives 0x3800000000000000, and a following insert 0x0001 gives 0x3800000040000000.
- R12: While reset is held, `wr_en` and `illegal` are low from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| rd_addr | output | 5 | Register file read address (target field) |
| rd_data | input | 64 | Register file read data, combinational from `rd_addr` |
| wr_en | output | 1 | Register write enable |
| wr_addr | output | 5 | Register write address |
| wr_data | output | 64 | Register write data |
| illegal | output | 1 | Unrecognised opcode pulse |

## Verification
Every cycle, the assertions check the write and illegal timing against the strobe, that illegal and write never coincide, and that the write address matches the strobed target field. They also check that the sign of an upper-half result follows immediate bit 15 and that the low 29 bits of every widened value are zero. The exact 64-bit patterns can only be shown by the bench's scenarios. Those scenarios cover normal values, signed zero, infinity and NaN, denormal round trips and the two-step constants. Back-to-back forwarding, and the absence of forwarding to a different register, also need the bench's sequencing against its register file model.

// File: rtl/fpimm_pkg.sv
// Shared types and format constants for the split-immediate FP loader.
// Assumes IEEE single (8/23) and double (11/52) binary formats.
package fpimm_pkg;
    localparam int SP_W     = 32;
    localparam int DP_W     = 64;
    localparam int SP_FRAC  = 23;
    localparam int DP_FRAC  = 52;
    localparam int DP_EXP   = 11;
    localparam int FRAC_GAP = DP_FRAC - SP_FRAC;       // 29
    localparam int EXP_ADJ  = 1023 - 127;              // 896
    localparam int IMM_W    = 16;
    localparam int REG_AW   = 5;

    typedef enum logic [1:0] {
        OPK_NONE  = 2'd0,
        OPK_UPPER = 2'd1,
        OPK_LOWER = 2'd2,
        OPK_BAD   = 2'd3
    } op_kind_e;
endpackage

// File: rtl/fpimm_decode.sv
// Instruction decoder: classifies the word and gathers the scattered
// immediate. Assumes bit 31 of instr is instruction bit 0 (MSB-first).
module fpimm_decode
    import fpimm_pkg::*;
#(
    parameter logic [5:0] PRIMARY_OP = 6'd22,
    parameter logic [4:0] XO_UPPER   = 5'b00011,
    parameter logic [4:0] XO_LOWER   = 5'b01011
) (
    input  logic              valid,
    input  logic [31:0]       instr,
    output op_kind_e          kind,
    output logic [REG_AW-1:0] target,
    output logic [IMM_W-1:0]  imm
);
    logic [5:0] prim;
    logic [4:0] ext;

    // Field extraction.
    always_comb begin
        prim   = instr[31:26];
        ext    = instr[5:1];
        target = instr[25:21];
        imm    = {instr[15:6], instr[20:16], instr[0]};
    end

    // Opcode classification.
    always_comb begin
        if (!valid)                  kind = OPK_NONE;
        else if (prim != PRIMARY_OP) kind = OPK_BAD;
        else if (ext == XO_UPPER)    kind = OPK_UPPER;
        else if (ext == XO_LOWER)    kind = OPK_LOWER;
        else                         kind = OPK_BAD;
    end
endmodule

// File: rtl/fp_narrow.sv
// Double-to-single narrowing by truncation (no rounding). Tiny values become
// single denormals; values too large for single saturate to infinity.
module fp_narrow
    import fpimm_pkg::*;
(
    input  logic [DP_W-1:0] dp,
    output logic [SP_W-1:0] sp
);
    logic              sgn;
    logic [DP_EXP-1:0] e;
    logic [SP_FRAC-1:0] m;
    logic [DP_EXP-1:0] e_down;
    logic [DP_EXP-1:0] sh;
    logic [SP_FRAC:0]  mant;

    // Range selection and re-biasing.
    always_comb begin
        sgn    = dp[DP_W-1];
        e      = dp[DP_W-2 -: DP_EXP];
        m      = dp[DP_FRAC-1 -: SP_FRAC];
        e_down = e - DP_EXP'(EXP_ADJ);
        sh     = DP_EXP'(EXP_ADJ + 1) - e;
        mant   = {1'b1, m} >> sh;
        if (e == '0)
            sp = {sgn, 31'd0};
        else if (e == '1)
            sp = {sgn, 8'hFF, m};
        else if (e >= DP_EXP'(EXP_ADJ + 255))
            sp = {sgn, 8'hFF, 23'd0};
        else if (e > DP_EXP'(EXP_ADJ))
            sp = {sgn, e_down[7:0], m};
        else if (sh > DP_EXP'(SP_FRAC + 1))
            sp = {sgn, 31'd0};
        else
            sp = {sgn, 8'h00, mant[SP_FRAC-1:0]};
    end
endmodule

// File: rtl/fp_widen.sv
// Exact single-to-double widening, including normalization of denormals.
module fp_widen
    import fpimm_pkg::*;
(
    input  logic [SP_W-1:0] sp,
    output logic [DP_W-1:0] dp
);
    logic               sgn;
    logic [7:0]         e;
    logic [SP_FRAC-1:0] f;
    logic [4:0]         lead;
    logic [DP_FRAC-1:0] dfrac;
    logic [DP_EXP-1:0]  dexp;

    // Leading-one search over the single fraction (for denormals).
    always_comb begin
        lead = '0;
        for (int i = 0; i < SP_FRAC; i++)
            if (f[i]) lead = i[4:0];
    end

    // Class selection and assembly of the double pattern.
    always_comb begin
        sgn   = sp[SP_W-1];
        e     = sp[30:23];
        f     = sp[SP_FRAC-1:0];
        dfrac = DP_FRAC'(f) << (6'd52 - 6'(lead));
        dexp  = DP_EXP'(lead) + DP_EXP'(EXP_ADJ - 22);
        if (e == 8'h00 && f == '0)
            dp = {sgn, 63'd0};
        else if (e == 8'hFF)
            dp = {sgn, 11'h7FF, f, {FRAC_GAP{1'b0}}};
        else if (e == 8'h00)
            dp = {sgn, dexp, dfrac};
        else
            dp = {sgn, DP_EXP'(e) + DP_EXP'(EXP_ADJ), f, {FRAC_GAP{1'b0}}};
    end
endmodule

// File: rtl/fp_imm_load_unit.sv
// Split-immediate FP constant loader. Reads the target register
// combinationally, returns the registered write one cycle after the strobe,
// and forwards its own pending write to a back-to-back insert on the same
// register. Assumes the register file commits wr_data on the clock edge that
// ends the cycle in which wr_en is high.
module fp_imm_load_unit
    import fpimm_pkg::*;
#(
    parameter logic [5:0] PRIMARY_OP = 6'd22,
    parameter logic [4:0] XO_UPPER   = 5'b00011,
    parameter logic [4:0] XO_LOWER   = 5'b01011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr,
    output logic [REG_AW-1:0] rd_addr,
    input  logic [DP_W-1:0]   rd_data,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [DP_W-1:0]   wr_data,
    output logic              illegal
);
    op_kind_e          kind;
    logic [REG_AW-1:0] target;
    logic [IMM_W-1:0]  imm;
    logic [DP_W-1:0]   src;
    logic [SP_W-1:0]   sp_old;
    logic [SP_W-1:0]   sp_new;
    logic [DP_W-1:0]   dp_new;
    logic              do_write;

    fpimm_decode #(
        .PRIMARY_OP(PRIMARY_OP),
        .XO_UPPER  (XO_UPPER),
        .XO_LOWER  (XO_LOWER)
    ) u_dec (
        .valid (instr_valid),
        .instr (instr),
        .kind  (kind),
        .target(target),
        .imm   (imm)
    );

    // Read address and forwarding of the write still in flight.
    always_comb begin
        rd_addr  = target;
        src      = (wr_en && wr_addr == target) ? wr_data : rd_data;
        do_write = (kind == OPK_UPPER) || (kind == OPK_LOWER);
    end

    fp_narrow u_narrow (.dp(src), .sp(sp_old));

    // Single-precision pattern for either instruction form.
    always_comb begin
        if (kind == OPK_LOWER) sp_new = {sp_old[SP_W-1:IMM_W], imm};
        else                   sp_new = {imm, {IMM_W{1'b0}}};
    end

    fp_widen u_widen (.sp(sp_new), .dp(dp_new));

    // Registered write-back and illegal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            illegal <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= do_write;
            illegal <= (kind == OPK_BAD);
            if (do_write) begin
                wr_addr <= target;
                wr_data <= dp_new;
            end
        end
    end
endmodule

// File: rtl/fp_imm_load_unit_chk.sv
// Protocol checker for fp_imm_load_unit; decodes legality from the port
// independently and relates strobes to write-back one cycle later.
module fp_imm_load_unit_chk #(
    parameter logic [5:0] PRIMARY_OP = 6'd22,
    parameter logic [4:0] XO_UPPER   = 5'b00011,
    parameter logic [4:0] XO_LOWER   = 5'b01011
) (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic [31:0] instr,
    input logic        wr_en,
    input logic [4:0]  wr_addr,
    input logic [63:0] wr_data,
    input logic        illegal
);
    logic legal_in;
    logic upper_in;

    // Independent legality view of the strobed word.
    always_comb begin
        upper_in = instr_valid && instr[31:26] == PRIMARY_OP && instr[5:1] == XO_UPPER;
        legal_in = instr_valid && instr[31:26] == PRIMARY_OP &&
                   (instr[5:1] == XO_UPPER || instr[5:1] == XO_LOWER);
    end

    p_write_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        legal_in |=> (wr_en && !illegal));

    p_no_strobe_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> (!wr_en && !illegal));

    p_illegal_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !legal_in) |=> (illegal && !wr_en));

    p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(illegal && wr_en));

    p_target_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
        legal_in |=> (wr_addr == $past(instr[25:21])));

    p_sign_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upper_in |=> (wr_data[63] == $past(instr[15])));

    p_widen_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[28:0] == 29'd0));

    p_reset_quiet_r12: assert property (@(posedge clk)
        !rst_n |=> (!wr_en && !illegal));
endmodule

bind fp_imm_load_unit fp_imm_load_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_valid(instr_valid),
    .instr      (instr),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .illegal    (illegal)
);

// File: tb/tb_fp_imm_load_unit.sv
// Scoreboard bench: the driver queues expected write-backs, the monitor
// pops and compares them against the register file port.
module tb_fp_imm_load_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [4:0]  rd_addr;
    logic [63:0] rd_data;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [63:0] wr_data;
    logic        illegal;

    logic [63:0] rf [32];
    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic        ill;
        logic [4:0]  a;
        logic [63:0] d;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    fp_imm_load_unit dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .illegal(illegal)
    );

    // Register file model: combinational read, commit at the edge.
    assign rd_data = rf[rd_addr];
    always @(posedge clk) if (wr_en) rf[wr_addr] <= wr_data;

    function automatic logic [31:0] enc(input logic [5:0] po, input logic [4:0] rt,
                                        input logic [15:0] imm, input logic [4:0] xo);
        return {po, rt, imm[5:1], imm[15:6], xo, imm[0]};
    endfunction

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic ill, input logic [4:0] a,
                         input logic [63:0] d, input string tag);
        exp_t e;
        e.ill = ill; e.a = a; e.d = d; e.tag = tag;
        sb.push_back(e);
        instr = w;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic up(input logic [4:0] r, input logic [15:0] imm, input logic [63:0] d, input string tag);
        issue(enc(6'd22, r, imm, 5'b00011), 1'b0, r, d, tag);
    endtask

    task automatic lo(input logic [4:0] r, input logic [15:0] imm, input logic [63:0] d, input string tag);
        issue(enc(6'd22, r, imm, 5'b01011), 1'b0, r, d, tag);
    endtask

    // Monitor: compare every write or illegal pulse with the queue head.
    always @(negedge clk) begin
        if (rst_n && (wr_en || illegal)) begin
            if (sb.size() == 0) begin
                vectors++; fails++;
                $display("FAIL R5: unexpected output wr_en=%b illegal=%b expected none", wr_en, illegal);
            end else begin
                exp_t e;
                e = sb.pop_front();
                vectors++;
                if (e.ill !== illegal || e.ill === wr_en ||
                    (!e.ill && (wr_addr !== e.a || wr_data !== e.d))) begin
                    fails++;
                    $display("FAIL %s: got ill=%b we=%b r%0d=%h expected ill=%b r%0d=%h",
                             e.tag, illegal, wr_en, wr_addr, wr_data, e.ill, e.a, e.d);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = '0;
        repeat (3) @(negedge clk);
        check64("R12 reset wr_en", {63'd0, wr_en}, 64'd0);
        check64("R12 reset illegal", {63'd0, illegal}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        up(5'd5,  16'h4000, 64'h4000000000000000, "R2 upper 0x4000");
        up(5'd6,  16'h4048, 64'h4009000000000000, "R2 upper 0x4048");
        up(5'd7,  16'h3E80, 64'h3FD0000000000000, "R2 upper 0x3E80");
        up(5'd8,  16'hC048, 64'hC009000000000000, "R3 negative sign");
        up(5'd9,  16'h8000, 64'h8000000000000000, "R9 negative zero");
        up(5'd10, 16'h0000, 64'h0000000000000000, "R9 positive zero");
        up(5'd11, 16'h7F80, 64'h7FF0000000000000, "R10 infinity");
        up(5'd12, 16'h7FC0, 64'h7FF8000000000000, "R10 nan");
        up(5'd13, 16'h0040, 64'h3800000000000000, "R11 denormal widen");
        @(negedge clk);
        lo(5'd13, 16'h0001, 64'h3800000040000000, "R11 denormal round trip");

        up(5'd4, 16'h3F80, 64'h3FF0000000000000, "R4 upper step");
        @(negedge clk);
        @(negedge clk);
        lo(5'd4, 16'h4000, 64'h3FF0080000000000, "R4 insert after gap");

        up(5'd3, 16'h4049, 64'h4009200000000000, "R1 upper imm bit0");
        lo(5'd3, 16'h0FD0, 64'h400921FA00000000, "R8 forward positive");
        up(5'd5, 16'hC049, 64'hC009200000000000, "R8 upper negative");
        lo(5'd5, 16'h0FD0, 64'hC00921FA00000000, "R8 forward negative");
        up(5'd20, 16'h4000, 64'h4000000000000000, "R8 other register");
        lo(5'd4, 16'h1234, 64'h3FF0024680000000, "R8 no false forward");

        issue(enc(6'd23, 5'd5, 16'h4000, 5'b00011), 1'b1, 5'd0, 64'd0, "R6 bad primary");
        issue(enc(6'd22, 5'd3, 16'h0000, 5'b00111), 1'b1, 5'd0, 64'd0, "R7 bad extended");

        instr = enc(6'd22, 5'd6, 16'h1111, 5'b00011);
        @(negedge clk);
        @(negedge clk);
        check64("R5 no strobe no write", {63'd0, wr_en}, 64'd0);

        repeat (3) @(negedge clk);
        check64("R6 register kept", rf[5], 64'hC00921FA00000000);
        check64("R7 register kept", rf[3], 64'h400921FA00000000);
        check64("R5 unstrobed register kept", rf[6], 64'h4009000000000000);
        check64("R4 register file value", rf[4], 64'h3FF0024680000000);
        check64("R5 scoreboard drained", 64'(sb.size()), 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule